// File: doc/BRIEF.md
# Result-Stationary Systolic FIR Array

This block is a short FIR filter built as a linear systolic array in which every processing element keeps one output sample in place. Coefficients enter at one end of the chain and step one element per clock toward the other end. Input samples enter at the far end and step one element per clock back the other way. Wherever a coefficient and a sample meet, the element multiplies them and adds the product to its resident sum. After it has seen every tap once, the element hands its finished sum to a shared, registered output port and clears itself for a later output sample.

Before a stream starts, the coefficients are shifted in through a small load port. The block then re-injects them by itself, highest tap first and wrapping around, one coefficient per accepted sample. Samples must arrive on alternate clock cycles in one unbroken run. The empty cycles between them are the bubbles that let the two counter-flowing streams meet in the right element, so each element does useful work on every second cycle. Samples that precede the first one of a run count as zero. A run whose length is a multiple of the tap count drains completely, so every output is produced.

Top module: `rsfir_array`

## Requirements
- R1: In the cycle after reset is released, `res_vld` is low and `res_out` is zero.
- R2: The m-th result of a run equals the signed sum over taps i of w_i·x(m−i), taken with full precision. Each output sample is accumulated from an empty sum.
- R3: Each accepted sample yields exactly one result, emitted in increasing m. At most one result appears per cycle. A run whose length is a multiple of TAPS produces no result beyond its own sample count.
- R4: With `smp_vld` high on alternate cycles, result m is valid exactly 2·TAPS+1−(m mod TAPS) cycles after the cycle in which sample m was presented. With three taps this is 7, 6 and 5 cycles.
- R5: Samples that precede the first one of a run count as zero, so result 0 is w0·x(0) and result 1 is w0·x(1)+w1·x(0).
- R6: Each cycle with `coef_vld` high shifts `coef_in` into the coefficient store. Of the last TAPS values loaded, the earliest becomes w0 and the latest becomes w(TAPS−1). Older values are discarded.
- R7: Reset clears the coefficient store. If a run starts without a load, every result is zero.
- R8: With the most negative sample and the most negative coefficient on every tap, the results are exact and do not overflow.
- R9: `res_out` is zero in every cycle where `res_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coef_in | input | WW | Signed coefficient to shift into the store |
| coef_vld | input | 1 | Shift `coef_in` into the coefficient store |
| smp_in | input | XW | Signed input sample |
| smp_vld | input | 1 | Sample present; high on alternate cycles only |
| res_out | output | XW+WW+clog2(TAPS) | Signed filter result, zero when not valid |
| res_vld | output | 1 | `res_out` holds the next output sample |

## Verification
The latency of a result depends on which element holds it. Result m is due 2·TAPS+1−(m mod TAPS) cycles after its sample, that is 7, 6 or 5 cycles with three taps. The bench records the cycle count of every sample it presents. On each valid output it compares the elapsed count with that formula, and compares the value with a convolution computed in the bench. Inputs are driven and outputs sampled on the falling edge, so every comparison looks at the registered state one full half-cycle after it changed.

// File: rtl/rsfir_pkg.sv
package rsfir_pkg;
  // index width for a counter or pointer that must address n slots
  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rsfir_wsrc.sv
module rsfir_wsrc #(
  parameter int TAPS = 3,
  parameter int WW   = 16,
  parameter int TW   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [WW-1:0] coef_in,
  input  logic                 coef_vld,
  input  logic                 beat,
  output logic signed [WW-1:0] w_out,
  output logic                 w_vld,
  output logic [TW-1:0]        w_tap
);
  // coefficient store: newest value enters at the top slot, oldest sits at slot 0
  logic signed [WW-1:0] bank [TAPS];
  logic [TW-1:0]        ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) bank[i] <= '0;
    end else if (coef_vld) begin
      for (int i = 0; i < TAPS - 1; i++) bank[i] <= bank[i+1];
      bank[TAPS-1] <= coef_in;
    end
  end

  // one coefficient per sample beat, highest tap first, wrapping downward
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= TW'(TAPS - 1);
      w_out <= '0;
      w_vld <= 1'b0;
      w_tap <= '0;
    end else begin
      w_vld <= beat;
      if (beat) begin
        w_out <= bank[ptr];
        w_tap <= ptr;
        ptr   <= (ptr == '0) ? TW'(TAPS - 1) : ptr - 1'b1;
      end
    end
  end

  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (rst)
    w_vld |-> (int'(w_tap) < TAPS)); // R6
endmodule

// File: rtl/rsfir_pe.sv
module rsfir_pe #(
  parameter int TAPS = 3,
  parameter int XW   = 16,
  parameter int WW   = 16,
  parameter int AW   = 34,
  parameter int TW   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [WW-1:0] w_in,
  input  logic                 w_vld,
  input  logic [TW-1:0]        w_tap,
  input  logic signed [XW-1:0] x_in,
  output logic                 done,
  output logic signed [AW-1:0] res
);
  localparam int PW = XW + WW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] sum;
  logic [TW-1:0]        cnt;
  logic                 last;

  always_comb begin
    prod = PW'(w_in) * PW'(x_in);
    sum  = acc + AW'(prod);
    last = (cnt == TW'(TAPS - 1));
  end

  // resident sum: updated only when a coefficient passes, i.e. every second cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      cnt  <= '0;
      done <= 1'b0;
      res  <= '0;
    end else begin
      done <= 1'b0;
      if (w_vld) begin
        if (last) begin
          res  <= sum;
          done <= 1'b1;
          acc  <= '0;
          cnt  <= '0;
        end else begin
          acc <= sum;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_LAST_TAP: assert property (@(posedge clk) disable iff (rst)
    (w_vld && last) |-> (w_tap == '0)); // R2
  AST_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
    w_vld |=> !w_vld); // R4
  AST_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> (acc == '0)); // R2
endmodule

// File: rtl/rsfir_drain.sv
module rsfir_drain #(
  parameter int TAPS = 3,
  parameter int AW   = 34
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TAPS-1:0]      done,
  input  logic signed [AW-1:0] res [TAPS],
  output logic signed [AW-1:0] res_out,
  output logic                 res_vld
);
  logic signed [AW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int k = 0; k < TAPS; k++) begin
      if (done[k]) pick = pick | res[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out <= '0;
      res_vld <= 1'b0;
    end else begin
      res_out <= pick;
      res_vld <= |done;
    end
  end

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done)); // R3
endmodule

// File: rtl/rsfir_array.sv
module rsfir_array #(
  parameter  int TAPS = 3,
  parameter  int XW   = 16,
  parameter  int WW   = 16,
  localparam int AW   = XW + WW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [WW-1:0] coef_in,
  input  logic                 coef_vld,
  input  logic signed [XW-1:0] smp_in,
  input  logic                 smp_vld,
  output logic signed [AW-1:0] res_out,
  output logic                 res_vld
);
  localparam int TW = rsfir_pkg::idx_w(TAPS);
  // sample path: TAPS-1 alignment stages, then one stage per hop between elements
  localparam int XL = 2 * TAPS - 1;

  logic signed [WW-1:0] w0_d;
  logic                 w0_v;
  logic [TW-1:0]        w0_t;
  logic signed [WW-1:0] wq_d [TAPS-1];
  logic                 wq_v [TAPS-1];
  logic [TW-1:0]        wq_t [TAPS-1];
  logic signed [XW-1:0] xs   [XL];
  logic [TAPS-1:0]      pe_done;
  logic signed [AW-1:0] pe_res [TAPS];

  rsfir_wsrc #(.TAPS(TAPS), .WW(WW), .TW(TW)) u_wsrc (
    .clk(clk), .rst(rst), .coef_in(coef_in), .coef_vld(coef_vld),
    .beat(smp_vld), .w_out(w0_d), .w_vld(w0_v), .w_tap(w0_t)
  );

  // forward coefficient hops and reverse sample hops, one register each
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS - 1; i++) begin
        wq_d[i] <= '0;
        wq_v[i] <= 1'b0;
        wq_t[i] <= '0;
      end
      for (int i = 0; i < XL; i++) xs[i] <= '0;
    end else begin
      wq_d[0] <= w0_d;
      wq_v[0] <= w0_v;
      wq_t[0] <= w0_t;
      for (int i = 1; i < TAPS - 1; i++) begin
        wq_d[i] <= wq_d[i-1];
        wq_v[i] <= wq_v[i-1];
        wq_t[i] <= wq_t[i-1];
      end
      xs[0] <= smp_vld ? smp_in : '0;
      for (int i = 1; i < XL; i++) xs[i] <= xs[i-1];
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_pe
    logic signed [WW-1:0] wk;
    logic                 wvk;
    logic [TW-1:0]        wtk;
    if (k == 0) begin : g_head
      assign wk  = w0_d;
      assign wvk = w0_v;
      assign wtk = w0_t;
    end else begin : g_body
      assign wk  = wq_d[k-1];
      assign wvk = wq_v[k-1];
      assign wtk = wq_t[k-1];
    end
    rsfir_pe #(.TAPS(TAPS), .XW(XW), .WW(WW), .AW(AW), .TW(TW)) u_pe (
      .clk(clk), .rst(rst), .w_in(wk), .w_vld(wvk), .w_tap(wtk),
      .x_in(xs[XL-1-k]), .done(pe_done[k]), .res(pe_res[k])
    );
  end

  rsfir_drain #(.TAPS(TAPS), .AW(AW)) u_drain (
    .clk(clk), .rst(rst), .done(pe_done), .res(pe_res),
    .res_out(res_out), .res_vld(res_vld)
  );

  AST_BEAT_GAP: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> !smp_vld); // R4
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_vld); // R1
endmodule

// File: tb/test_rsfir_array.sv
module test_rsfir_array;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 3;
  localparam int XW = 16;
  localparam int WW = 16;
  localparam int AW = XW + WW + $clog2(NT);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic signed [WW-1:0] coef_in = '0;
  logic                 coef_vld = 1'b0;
  logic signed [XW-1:0] smp_in = '0;
  logic                 smp_vld = 1'b0;
  logic signed [AW-1:0] res_out;
  logic                 res_vld;

  rsfir_array #(.TAPS(NT), .XW(XW), .WW(WW)) i_rsfir_array (
    .clk(clk), .rst(rst), .coef_in(coef_in), .coef_vld(coef_vld),
    .smp_in(smp_in), .smp_vld(smp_vld), .res_out(res_out), .res_vld(res_vld)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int     checks = 0;
  int     fails = 0;
  bit     finished = 1'b0;
  int     cw [NT];
  int     sx [64];
  int     dc [64];
  int     nsmp = 0;
  int     outn = 0;
  string  vtag = "R2";
  longint got;
  longint want;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_y(input int m);
    longint s = 0;
    for (int i = 0; i < NT; i++)
      if (m - i >= 0) s += longint'(cw[i]) * longint'(sx[m-i]);
    return s;
  endfunction

  // output monitor: value, order and due cycle of every result
  always @(negedge clk) begin
    if (!rst) begin
      got = longint'($signed(res_out));
      if (res_vld) begin
        if (outn >= nsmp) begin
          chk(1'b0, "R3 result beyond sample count", outn, nsmp - 1);
        end else begin
          want = ref_y(outn);
          chk(got == want, (outn < 2) ? {vtag, " R5"} : vtag, got, want);
          chk(cyc - dc[outn] == 2 * NT + 1 - (outn % NT), "R4 latency",
              cyc - dc[outn], 2 * NT + 1 - (outn % NT));
        end
        outn++;
      end else begin
        chk(got == 0, "R9 idle output", got, 0);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    coef_vld = 1'b0;
    smp_vld = 1'b0;
    repeat (3) @(negedge clk);
    nsmp = 0;
    outn = 0;
    rst = 1'b0;
  endtask

  task automatic load(input int v);
    @(negedge clk);
    coef_in = WW'(v);
    coef_vld = 1'b1;
    @(negedge clk);
    coef_vld = 1'b0;
  endtask

  task automatic send(input int v);
    @(negedge clk);
    smp_in = XW'(v);
    smp_vld = 1'b1;
    sx[nsmp] = v;
    dc[nsmp] = cyc;
    nsmp++;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic flush(input string tag);
    repeat (20) @(negedge clk);
    chk(outn == nsmp, tag, outn, nsmp);
  endtask

  function automatic int rnd16();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  initial begin
    void'($urandom(32'd7411));
    do_reset();
    @(negedge clk);
    chk(res_vld == 1'b0, "R1 valid after reset", longint'(res_vld), 0);
    chk(res_out == '0, "R1 output after reset", longint'($signed(res_out)), 0);

    // directed: impulse and short pattern
    vtag = "R2 directed";
    cw = '{3, -2, 5};
    load(3); load(-2); load(5);
    send(1); send(0); send(0); send(4); send(-1); send(2); send(0); send(0); send(7);
    flush("R3 directed count");

    // random run of thirty samples
    do_reset();
    vtag = "R2 random";
    for (int i = 0; i < NT; i++) cw[i] = rnd16();
    for (int i = 0; i < NT; i++) load(cw[i]);
    for (int i = 0; i < 30; i++) send(rnd16());
    flush("R3 random count");

    // four loads: the first value must fall out of the store
    do_reset();
    vtag = "R6 coefficient order";
    load(12345);
    cw = '{-7, 11, 2};
    load(-7); load(11); load(2);
    for (int i = 0; i < 6; i++) send(rnd16());
    flush("R3 reload count");

    // no load after reset: store is empty
    do_reset();
    vtag = "R7 cleared coefficients";
    cw = '{0, 0, 0};
    for (int i = 0; i < 6; i++) send(rnd16());
    flush("R3 cleared count");

    // full-scale negative operands
    do_reset();
    vtag = "R8 full scale";
    cw = '{-32768, -32768, -32768};
    for (int i = 0; i < NT; i++) load(-32768);
    for (int i = 0; i < 6; i++) send(-32768);
    flush("R3 full scale count");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", outn, nsmp);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule